// File: doc/BRIEF.md
# Pin-Controlled Power-Down Hold Unit

This unit sits between the pads of a programmable logic block and its internal logic array, and implements a pin-driven sleep mode. When a configuration enable is set, two dedicated request pins are watched; if either is high the unit enters power-down. At that moment it captures the ordinary input pin levels, the values the internal logic drives toward the output pads and the output-enable of each pad. It then presents those captured values on both sides for as long as power-down lasts, and it stops the internal registers by dropping their clock enable. Pads that were high-impedance when power-down began therefore stay high-impedance, driven pads keep their levels, and input pin activity never reaches the array.

When the configuration enable is clear the two request pins are ordinary pins: their levels reach the array and the internal logic controls their output enables. When it is set they are reserved for the power-down function: the array sees them as constant low and their output drivers are held off.

A small state machine with three states sequences the mode. RUN passes everything through live. DOWN holds all captured values. WAKE is a one-cycle release stage that still holds the captured values. The transitions are: RUN to DOWN (request seen at an edge, capture taken), DOWN to WAKE (both pins seen low at an edge), WAKE to RUN (still no request), WAKE to DOWN (request returns, no new capture), and DOWN to DOWN and RUN to RUN otherwise.

Top module: `pdn_hold_ctrl`

## Requirements
- R1: With `cfg_pd_en` low, the request pins never change the mode (state stays RUN), `arr_pd` equals `pd_pin` bit for bit and `pdpin_oe` equals `core_pdpin_oe`.
- R2: With `cfg_pd_en` high, a rising clock edge in RUN at which `pd_pin[0]` or `pd_pin[1]` is high moves the unit to DOWN; `pd_active` is 1 from that edge on.
- R3: From the entry edge until the unit returns to RUN, `pad_out` equals the value `core_out` had at the entry edge, whatever `core_out` does meanwhile.
- R4: From the entry edge until the return to RUN, `pad_oe` equals the value `core_oe` had at the entry edge, so a pad with enable 0 at entry stays high-impedance throughout.
- R5: From the entry edge until the return to RUN, `arr_in` equals the value `pin_in` had at the entry edge; `pin_in` changes have no effect on it.
- R6: With `cfg_pd_en` high, `arr_pd` is 2'b00 and `pdpin_oe` is 2'b00 whatever the pins and the internal logic do.
- R7: `core_run` is 1 only in RUN while no request is present (request = `cfg_pd_en` and either pin high); it is 0 in DOWN, in WAKE, and during the RUN cycle in which a request is presented, so internal registers do not advance at the entry edge.
- R8: In DOWN, an edge at which no request is present moves to WAKE, where all held values are still presented and `pd_active` stays 1; the next edge with no request moves to RUN, where `arr_in`, `pad_out` and `pad_oe` follow their live sources and `pd_active` is 0.
- R9: A request present at an edge in WAKE returns the unit to DOWN without a new capture; the values held since the original entry remain on `arr_in`, `pad_out` and `pad_oe`.
- R10: While `rst_n` is low the unit is in RUN: `pd_active` is 0, outputs follow their live sources and the held values are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_pd_en | input | 1 | Configuration bit arming the power-down function |
| pd_pin | input | 2 | Levels of the two power-down request pins |
| pin_in | input | N_IN | Levels of the ordinary input pins |
| core_out | input | N_OUT | Output values driven by the internal logic |
| core_oe | input | N_OUT | Output enables driven by the internal logic |
| core_pdpin_oe | input | 2 | Output enables the internal logic requests for the two request pins |
| arr_in | output | N_IN | Input values delivered to the logic array |
| arr_pd | output | 2 | Request pin levels as seen by the logic array |
| pad_out | output | N_OUT | Output values delivered to the pads |
| pad_oe | output | N_OUT | Output enables delivered to the pads |
| pdpin_oe | output | 2 | Output enables for the two request pins |
| core_run | output | 1 | Clock enable for the internal registers |
| pd_active | output | 1 | 1 while in DOWN or WAKE |

## Verification
Two functions that collide are entry capture and live change: the bench changes `pin_in`, `core_out` and `core_oe` in the very cycle the request first rises, and judges that the held values are the ones present at the entry edge, not those presented afterwards. The other collision is release against re-request: the request is dropped for exactly one cycle so the unit reaches WAKE and is pulled back to DOWN at the next edge, and the bench judges that the original capture survives. A bench model of the three states, driven by random pins, random internal values and occasional toggling of the enable, predicts every output each cycle.

// File: rtl/pdn_pkg.sv
package pdn_pkg;

    typedef enum logic [1:0] {
        PD_RUN  = 2'd0,
        PD_DOWN = 2'd1,
        PD_WAKE = 2'd2
    } pd_state_e;

    localparam int unsigned PD_PINS = 2;

endpackage

// File: rtl/pdn_pin_iso.sv
module pdn_pin_iso
    import pdn_pkg::*;
(
    input  logic               cfg_en,
    input  logic [PD_PINS-1:0] pd_pin,
    input  logic [PD_PINS-1:0] core_oe,
    output logic [PD_PINS-1:0] arr_pd,
    output logic [PD_PINS-1:0] pin_oe,
    output logic               req
);

    // Request pins become reserved while the function is armed.
    for (genvar k = 0; k < PD_PINS; k++) begin : g_iso
        always_comb begin
            arr_pd[k] = cfg_en ? 1'b0 : pd_pin[k];
            pin_oe[k] = cfg_en ? 1'b0 : core_oe[k];
        end
    end

    always_comb req = cfg_en && (|pd_pin);

endmodule

// File: rtl/pdn_fsm.sv
module pdn_fsm
    import pdn_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req,
    output pd_state_e state,
    output logic      capture,
    output logic      hold_sel,
    output logic      core_run,
    output logic      pd_active
);

    pd_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PD_RUN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            PD_RUN:  nxt = req ? PD_DOWN : PD_RUN;
            PD_DOWN: nxt = req ? PD_DOWN : PD_WAKE;
            PD_WAKE: nxt = req ? PD_DOWN : PD_RUN;
            default: nxt = PD_RUN;
        endcase
    end

    always_comb begin
        capture   = 1'b0;
        hold_sel  = 1'b1;
        core_run  = 1'b0;
        pd_active = 1'b1;
        unique case (state)
            PD_RUN: begin
                capture   = req;
                hold_sel  = 1'b0;
                core_run  = !req;
                pd_active = 1'b0;
            end
            PD_DOWN, PD_WAKE: begin
                capture   = 1'b0;
                hold_sel  = 1'b1;
                core_run  = 1'b0;
                pd_active = 1'b1;
            end
            default: begin
                capture   = 1'b0;
                hold_sel  = 1'b0;
                core_run  = 1'b0;
                pd_active = 1'b0;
            end
        endcase
    end

    AST_ENTRY_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PD_RUN && req) |=> (state == PD_DOWN)); // R2

    AST_RELEASE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PD_DOWN && !req) |=> (state == PD_WAKE)); // R8

    AST_WAKE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PD_WAKE && req) |=> (state == PD_DOWN)); // R9

    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PD_WAKE && !req) |=> (state == PD_RUN)); // R8

endmodule

// File: rtl/pdn_hold_bank.sv
module pdn_hold_bank #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         hold_sel,
    input  logic [W-1:0] live,
    output logic [W-1:0] q
);

    logic [W-1:0] held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       held <= '0;
        else if (capture) held <= live;
    end

    for (genvar b = 0; b < W; b++) begin : g_lane
        always_comb q[b] = hold_sel ? held[b] : live[b];
    end

endmodule

// File: rtl/pdn_hold_ctrl.sv
module pdn_hold_ctrl
    import pdn_pkg::*;
#(
    parameter int unsigned N_IN  = 8,
    parameter int unsigned N_OUT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_pd_en,
    input  logic [1:0]         pd_pin,
    input  logic [N_IN-1:0]    pin_in,
    input  logic [N_OUT-1:0]   core_out,
    input  logic [N_OUT-1:0]   core_oe,
    input  logic [1:0]         core_pdpin_oe,
    output logic [N_IN-1:0]    arr_in,
    output logic [1:0]         arr_pd,
    output logic [N_OUT-1:0]   pad_out,
    output logic [N_OUT-1:0]   pad_oe,
    output logic [1:0]         pdpin_oe,
    output logic               core_run,
    output logic               pd_active
);

    pd_state_e state;
    logic      req;
    logic      capture;
    logic      hold_sel;

    pdn_pin_iso u_iso (
        .cfg_en  (cfg_pd_en),
        .pd_pin  (pd_pin),
        .core_oe (core_pdpin_oe),
        .arr_pd  (arr_pd),
        .pin_oe  (pdpin_oe),
        .req     (req)
    );

    pdn_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .state     (state),
        .capture   (capture),
        .hold_sel  (hold_sel),
        .core_run  (core_run),
        .pd_active (pd_active)
    );

    pdn_hold_bank #(.W(N_IN)) u_in_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .hold_sel (hold_sel),
        .live     (pin_in),
        .q        (arr_in)
    );

    pdn_hold_bank #(.W(N_OUT)) u_out_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .hold_sel (hold_sel),
        .live     (core_out),
        .q        (pad_out)
    );

    pdn_hold_bank #(.W(N_OUT)) u_oe_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .hold_sel (hold_sel),
        .live     (core_oe),
        .q        (pad_oe)
    );

    AST_DISARMED_STAYS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_pd_en && !pd_active) |=> !pd_active); // R1

    AST_ENTRY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_active) |-> (pad_out == $past(core_out))); // R3

    AST_ENTRY_OE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_active) |-> (pad_oe == $past(core_oe))); // R4

    AST_ENTRY_IN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_active) |-> (arr_in == $past(pin_in))); // R5

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active && $past(pd_active)) |-> ($stable(pad_out) && $stable(pad_oe) && $stable(arr_in))); // R3

    AST_ARMED_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_pd_en |-> (arr_pd == 2'b00 && pdpin_oe == 2'b00)); // R6

    AST_FROZEN_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        pd_active |-> !core_run); // R7

endmodule

// File: tb/tb_pdn_hold_ctrl.sv
`timescale 1ns/1ps
module tb_pdn_hold_ctrl;

    localparam int NI = 8;
    localparam int NO = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_pd_en = 1'b0;
    logic [1:0]    pd_pin = 2'b00;
    logic [NI-1:0] pin_in = '0;
    logic [NO-1:0] core_out = '0;
    logic [NO-1:0] core_oe = '0;
    logic [1:0]    core_pdpin_oe = 2'b00;
    logic [NI-1:0] arr_in;
    logic [1:0]    arr_pd;
    logic [NO-1:0] pad_out;
    logic [NO-1:0] pad_oe;
    logic [1:0]    pdpin_oe;
    logic          core_run;
    logic          pd_active;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model: 0 run, 1 down, 2 wake
    int            ms = 0;
    logic [NI-1:0] h_in = '0;
    logic [NO-1:0] h_out = '0;
    logic [NO-1:0] h_oe = '0;

    always #10 clk = ~clk;

    pdn_hold_ctrl #(.N_IN(NI), .N_OUT(NO)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_pd_en(cfg_pd_en), .pd_pin(pd_pin),
        .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
        .core_pdpin_oe(core_pdpin_oe), .arr_in(arr_in), .arr_pd(arr_pd),
        .pad_out(pad_out), .pad_oe(pad_oe), .pdpin_oe(pdpin_oe),
        .core_run(core_run), .pd_active(pd_active)
    );

    function automatic bit req_f();
        return cfg_pd_en && (|pd_pin);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // compare all outputs against model, mid low phase
    task automatic check_all();
        bit held = (ms != 0);
        chk("R5 arr_in", 32'(arr_in), held ? 32'(h_in) : 32'(pin_in));
        chk("R3 pad_out", 32'(pad_out), held ? 32'(h_out) : 32'(core_out));
        chk("R4 pad_oe", 32'(pad_oe), held ? 32'(h_oe) : 32'(core_oe));
        chk("R7 core_run", 32'(core_run), 32'((ms == 0) && !req_f()));
        chk("R8 pd_active", 32'(pd_active), 32'(held));
        if (cfg_pd_en) begin
            chk("R6 arr_pd", 32'(arr_pd), 32'd0);
            chk("R6 pdpin_oe", 32'(pdpin_oe), 32'd0);
        end else begin
            chk("R1 arr_pd", 32'(arr_pd), 32'(pd_pin));
            chk("R1 pdpin_oe", 32'(pdpin_oe), 32'(core_pdpin_oe));
        end
    endtask

    task automatic model_edge();
        bit r = req_f();
        case (ms)
            0: if (r) begin ms = 1; h_in = pin_in; h_out = core_out; h_oe = core_oe; end
            1: if (!r) ms = 2;
            default: ms = r ? 1 : 0;
        endcase
    endtask

    // one cycle: drive at negedge, check, model update at posedge
    task automatic cycle(input bit en, input logic [1:0] pd, input bit rnd_data);
        @(negedge clk);
        cfg_pd_en = en;
        pd_pin = pd;
        if (rnd_data) begin
            pin_in = NI'($urandom);
            core_out = NO'($urandom);
            core_oe = NO'($urandom);
            core_pdpin_oe = 2'($urandom);
        end
        #3;
        check_all();
        @(posedge clk);
        model_edge();
    endtask

    initial begin : watchdog
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [NO-1:0] keep_out;
        logic [1:0] lvl;
        bit en;
        void'($urandom(32'd4242));

        // R10 reset state
        pin_in = 8'hA5; core_out = 8'h3C; core_oe = 8'h0F;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 pd_active", 32'(pd_active), 32'd0);
        chk("R10 arr_in", 32'(arr_in), 32'h0A5);
        chk("R10 pad_oe", 32'(pad_oe), 32'h00F);
        cfg_pd_en = 1'b1; pd_pin = 2'b01; #1;
        chk("R10 state stays run in reset", 32'(pd_active), 32'd0);
        cfg_pd_en = 1'b0; pd_pin = 2'b00;
        @(negedge clk);
        rst_n = 1'b1;

        // R1 disarmed: pins ignored for mode
        for (int i = 0; i < 6; i++) cycle(1'b0, 2'($urandom), 1'b1);

        // R2/R4 entry on second pin with data changing right at entry, oe partly low
        cycle(1'b1, 2'b00, 1'b1);
        @(negedge clk);
        cfg_pd_en = 1'b1; pd_pin = 2'b10;
        core_oe = 8'b0101_0000; core_out = 8'hE7; pin_in = 8'h19;
        #3; check_all(); @(posedge clk); model_edge();
        @(negedge clk); #3;
        chk("R2 entry via pin b", 32'(pd_active), 32'd1);
        chk("R4 hi-z lanes stay off", 32'(pad_oe), 32'h050);
        keep_out = pad_out;
        @(posedge clk); model_edge();
        for (int i = 0; i < 5; i++) cycle(1'b1, 2'b11, 1'b1);
        chk("R3 held output after churn", 32'(pad_out), 32'(keep_out));

        // R9 drop one cycle, re-request in WAKE
        cycle(1'b1, 2'b00, 1'b1);
        chk("R9 in wake", 32'(ms), 32'd2);
        cycle(1'b1, 2'b01, 1'b1);
        chk("R9 back to down", 32'(ms), 32'd1);
        cycle(1'b1, 2'b01, 1'b1);
        chk("R9 original capture kept", 32'(pad_out), 32'(keep_out));

        // R8 release
        cycle(1'b1, 2'b00, 1'b1);
        cycle(1'b1, 2'b00, 1'b1);
        cycle(1'b1, 2'b00, 1'b1);
        chk("R8 back in run", 32'(ms), 32'd0);

        // random phase
        lvl = 2'b00; en = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 64) == 0) en = ~en;
            if (($urandom % 6) == 0) lvl = (lvl != 2'b00) ? 2'b00 : 2'(1 + ($urandom % 3));
            cycle(en, lvl, ($urandom % 4) != 0);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule